// File: doc/BRIEF.md
# Regression-Based Wavelength State Predictor

This block picks the optical wavelength state for one router's photonic link ahead of time, rather than reacting to buffer fill. Throughout a fixed-length window it counts per-router traffic events on a bank of saturating feature counters. When the window closes it freezes those counts, together with a flag that marks the cache router and the wavelength count now in use. It then runs a signed fixed-point dot product of this feature vector against a loadable weight vector, and the result is a prediction of how many packets will be injected in the next window.

A negative prediction is taken as zero. The selector compares the predicted traffic, in bits, against what each state can carry over a window. It then picks the smallest state that is large enough, or the lowest state when the prediction falls under a programmable floor. The new state and the prediction are latched together and marked by a one-cycle done pulse.

The weights are trained elsewhere and written in through a simple write port.

Top module: `inj_predict`

## Requirements
- R1: While rst_ni is low, state_o is 4 (64 wavelengths), done_o is 0 and pred_o is 0. All weights reset to 0.
- R2: Each event counter counts the cycles in which its strobe evt_i[i] is high. It holds at 2^CNT_W-1 and does not wrap.
- R3: All event counters restart from zero at every window boundary, so a window with no strobes contributes zero from every event feature.
- R4: The feature vector has NUM_FEAT entries. Index 0 is is_l3_i (0 or 1). Index i+1 is the count for evt_i[i]. Index NUM_FEAT-1 is the wavelength count of state_o at the window's closing edge. pred_o equals the sum of weight[i] × feature[i], with each weight a two's-complement number, clamped to 0 when the sum is negative.
- R5: The window closes on the WIN_LEN-th rising edge after reset release and on every WIN_LEN-th edge after that. Strobes sampled on the edges of the window, including its closing edge, belong to it. done_o is high for exactly one cycle, starting NUM_FEAT+1 edges after the closing edge. state_o and pred_o change only as done_o rises.
- R6: When pred_o < low_thr_i, state_o is 0 (8 wavelengths). A prediction equal to low_thr_i does not select state 0.
- R7: Otherwise state_o is the smallest code k in 1..4 with pred × pkt_bits_i ≤ (16·k) × wl_rate_i. Code 1 is 16 wavelengths, 2 is 32, 3 is 48 and 4 is 64. The configuration inputs are sampled on the edge that raises done_o.
- R8: When no code from 1 to 4 satisfies the inequality in R7, state_o is 4.
- R9: A rising edge with wgt_we_i high stores wgt_data_i as weight[wgt_addr_i] when wgt_addr_i < NUM_FEAT. Writes to higher addresses change nothing. Weights are written while no prediction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_FEAT-2 | Per-feature event strobes |
| is_l3_i | input | 1 | Router is the shared-cache router |
| wgt_we_i | input | 1 | Weight write enable |
| wgt_addr_i | input | $clog2(NUM_FEAT) | Weight index |
| wgt_data_i | input | WGT_W | Signed weight value |
| pkt_bits_i | input | PKT_W | Packet size in bits |
| wl_rate_i | input | RATE_W | Bits one wavelength carries per window |
| low_thr_i | input | PRED_W | Floor below which the lowest state is used |
| state_o | output | 3 | Chosen wavelength state code |
| done_o | output | 1 | One-cycle pulse when a new state is latched |
| pred_o | output | PRED_W | Clamped prediction |

## Verification
The bench keeps 30 features but narrows the event counters to CNT_W=4 and shortens the window to WIN_LEN=64. A window in which every strobe is held high therefore drives all counters into saturation, and about thirty windows cover every state, with timing checked at the real done offset. The default 16-bit weights keep the signed products at full width. Bench-chosen rates and packet sizes place predictions exactly on the capacity boundary and on the low threshold. A window of all-negative weights exercises the clamp.

// File: rtl/inj_predict_pkg.sv
package inj_predict_pkg;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned LVL_W   = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_LOW = 3'd0;
  localparam lvl_t LVL_TOP = 3'd4;

  // wavelength count of a state code
  function automatic int unsigned lvl_wl(lvl_t l, int unsigned step);
    return (l == LVL_LOW) ? step / 2 : step * int'(l);
  endfunction
endpackage

// File: rtl/inj_feat_cnt.sv
module inj_feat_cnt #(
  parameter int unsigned NUM_EVT = 28,
  parameter int unsigned CNT_W   = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_EVT-1:0]              evt_i,
  input  logic                            clr_i,
  output logic [NUM_EVT-1:0][CNT_W-1:0]   val_o
);
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q, cnt_d;
    // saturating increment; val_o includes this cycle's strobe
    assign cnt_d    = (evt_i[g] && (cnt_q != '1)) ? cnt_q + 1'b1 : cnt_q;
    assign val_o[g] = cnt_d;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/inj_mac.sv
module inj_mac #(
  parameter int unsigned NUM_FEAT = 30,
  parameter int unsigned FEAT_W   = 16,
  parameter int unsigned WGT_W    = 16,
  parameter int unsigned ACC_W    = 38,
  localparam int unsigned IDX_W   = $clog2(NUM_FEAT),
  localparam int unsigned PROD_W  = FEAT_W + 1 + WGT_W
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                start_i,
  input  logic [NUM_FEAT-1:0][FEAT_W-1:0]     feat_i,
  input  logic [NUM_FEAT-1:0][WGT_W-1:0]      wgt_i,
  output logic signed [ACC_W-1:0]             acc_o,
  output logic                                fin_o
);
  logic                     busy_q, fin_q;
  logic [IDX_W-1:0]         idx_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [FEAT_W:0]   f_s;
  logic signed [WGT_W-1:0]  w_s;
  logic signed [PROD_W-1:0] prod;

  assign f_s  = $signed({1'b0, feat_i[idx_q]});
  assign w_s  = $signed(wgt_i[idx_q]);
  assign prod = f_s * w_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        acc_q  <= '0;
      end else if (busy_q) begin
        acc_q <= acc_q + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        idx_q <= idx_q + 1'b1;
        if (idx_q == IDX_W'(NUM_FEAT-1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign acc_o = acc_q;
  assign fin_o = fin_q;
endmodule

// File: rtl/inj_lvl_sel.sv
module inj_lvl_sel
  import inj_predict_pkg::*;
#(
  parameter int unsigned PRED_W  = 37,
  parameter int unsigned PKT_W   = 8,
  parameter int unsigned RATE_W  = 16,
  parameter int unsigned WL_STEP = 16,
  localparam int unsigned CAP_W  = PRED_W + PKT_W
) (
  input  logic [PRED_W-1:0] pred_i,
  input  logic [PKT_W-1:0]  pkt_bits_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [PRED_W-1:0] low_thr_i,
  output lvl_t              lvl_o
);
  logic [CAP_W-1:0]   demand;
  logic [NUM_LVL:1]   fits;

  assign demand = CAP_W'(pred_i) * CAP_W'(pkt_bits_i);

  for (genvar k = 1; k <= NUM_LVL; k++) begin : g_cap
    assign fits[k] = demand <= CAP_W'(WL_STEP * k) * CAP_W'(rate_i);
  end

  always_comb begin
    lvl_o = LVL_TOP;
    for (int k = NUM_LVL; k >= 1; k--) begin
      if (fits[k]) lvl_o = lvl_t'(k);
    end
    if (pred_i < low_thr_i) lvl_o = LVL_LOW;
  end
endmodule

// File: rtl/inj_predict.sv
module inj_predict
  import inj_predict_pkg::*;
#(
  parameter int unsigned NUM_FEAT = 30,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned WGT_W    = 16,
  parameter int unsigned WIN_LEN  = 500,
  parameter int unsigned WL_STEP  = 16,
  parameter int unsigned PKT_W    = 8,
  parameter int unsigned RATE_W   = 16,
  localparam int unsigned NUM_EVT = NUM_FEAT - 2,
  localparam int unsigned AW      = $clog2(NUM_FEAT),
  localparam int unsigned WIN_W   = $clog2(WIN_LEN),
  localparam int unsigned WLC_W   = $clog2(WL_STEP * NUM_LVL + 1),
  localparam int unsigned FEAT_W  = (CNT_W > WLC_W) ? CNT_W : WLC_W,
  localparam int unsigned ACC_W   = FEAT_W + WGT_W + 1 + $clog2(NUM_FEAT),
  localparam int unsigned PRED_W  = ACC_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               is_l3_i,
  input  logic               wgt_we_i,
  input  logic [AW-1:0]      wgt_addr_i,
  input  logic [WGT_W-1:0]   wgt_data_i,
  input  logic [PKT_W-1:0]   pkt_bits_i,
  input  logic [RATE_W-1:0]  wl_rate_i,
  input  logic [PRED_W-1:0]  low_thr_i,
  output logic [LVL_W-1:0]   state_o,
  output logic               done_o,
  output logic [PRED_W-1:0]  pred_o
);
  logic [WIN_W-1:0]                   win_q;
  logic                               win_end;
  logic [NUM_EVT-1:0][CNT_W-1:0]      cnt_val;
  logic [NUM_FEAT-1:0][FEAT_W-1:0]    snap_q;
  logic [NUM_FEAT-1:0][WGT_W-1:0]     wgt_q;
  logic signed [ACC_W-1:0]            acc;
  logic                               fin;
  logic [PRED_W-1:0]                  pred_c, pred_q;
  lvl_t                               lvl_nxt, state_q;
  logic                               done_q;

  assign win_end = (win_q == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= '0;
    else if (win_end) win_q <= '0;
    else              win_q <= win_q + 1'b1;
  end

  inj_feat_cnt #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (win_end),
    .val_o  (cnt_val)
  );

  // freeze the feature vector at window close
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else if (win_end) begin
      snap_q[0] <= FEAT_W'(is_l3_i);
      for (int i = 0; i < NUM_EVT; i++) snap_q[i+1] <= FEAT_W'(cnt_val[i]);
      snap_q[NUM_FEAT-1] <= FEAT_W'(lvl_wl(state_q, WL_STEP));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wgt_q <= '0;
    else if (wgt_we_i && (32'(wgt_addr_i) < NUM_FEAT)) wgt_q[wgt_addr_i] <= wgt_data_i;
  end

  inj_mac #(
    .NUM_FEAT (NUM_FEAT),
    .FEAT_W   (FEAT_W),
    .WGT_W    (WGT_W),
    .ACC_W    (ACC_W)
  ) u_mac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (win_end),
    .feat_i  (snap_q),
    .wgt_i   (wgt_q),
    .acc_o   (acc),
    .fin_o   (fin)
  );

  assign pred_c = acc[ACC_W-1] ? '0 : acc[PRED_W-1:0];

  inj_lvl_sel #(
    .PRED_W  (PRED_W),
    .PKT_W   (PKT_W),
    .RATE_W  (RATE_W),
    .WL_STEP (WL_STEP)
  ) u_sel (
    .pred_i     (pred_c),
    .pkt_bits_i (pkt_bits_i),
    .rate_i     (wl_rate_i),
    .low_thr_i  (low_thr_i),
    .lvl_o      (lvl_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LVL_TOP;
      pred_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) begin
        state_q <= lvl_nxt;
        pred_q  <= pred_c;
      end
    end
  end

  assign state_o = state_q;
  assign pred_o  = pred_q;
  assign done_o  = done_q;
endmodule

// File: rtl/inj_predict_chk.sv
module inj_predict_chk
  import inj_predict_pkg::*;
#(
  parameter int unsigned PRED_W  = 37,
  parameter int unsigned PKT_W   = 8,
  parameter int unsigned RATE_W  = 16,
  parameter int unsigned WL_STEP = 16,
  localparam int unsigned CAP_W  = PRED_W + PKT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic [LVL_W-1:0]  state_o,
  input logic [PRED_W-1:0] pred_o,
  input logic [PRED_W-1:0] low_thr_i,
  input logic [PKT_W-1:0]  pkt_bits_i,
  input logic [RATE_W-1:0] wl_rate_i
);
  logic [CAP_W-1:0] demand, cap_cur, cap_below;

  assign demand    = CAP_W'(pred_o) * CAP_W'(pkt_bits_i);
  assign cap_cur   = CAP_W'(lvl_wl(lvl_t'(state_o), WL_STEP)) * CAP_W'(wl_rate_i);
  assign cap_below = CAP_W'(lvl_wl(lvl_t'(state_o - 1'b1), WL_STEP)) * CAP_W'(wl_rate_i);

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_out_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(state_o) && $stable(pred_o)));

  assert_low_pick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((pred_o < low_thr_i) == (state_o == LVL_LOW)));

  assert_fits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && state_o != LVL_LOW && state_o != LVL_TOP) |-> (demand <= cap_cur));

  assert_smallest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && state_o > 3'd1) |-> (demand > cap_below));

  assert_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= LVL_TOP);
endmodule

bind inj_predict inj_predict_chk #(
  .PRED_W  (PRED_W),
  .PKT_W   (PKT_W),
  .RATE_W  (RATE_W),
  .WL_STEP (WL_STEP)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .state_o    (state_o),
  .pred_o     (pred_o),
  .low_thr_i  (low_thr_i),
  .pkt_bits_i (pkt_bits_i),
  .wl_rate_i  (wl_rate_i)
);

// File: tb/tb_inj_predict.sv
module tb_inj_predict;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_FEAT = 30;
  localparam int CNT_W    = 4;
  localparam int WGT_W    = 16;
  localparam int WIN_LEN  = 64;
  localparam int WL_STEP  = 16;
  localparam int PKT_W    = 8;
  localparam int RATE_W   = 16;
  localparam int NUM_EVT  = NUM_FEAT - 2;
  localparam int AW       = $clog2(NUM_FEAT);
  localparam int WLC_W    = $clog2(WL_STEP * 4 + 1);
  localparam int FEAT_W   = (CNT_W > WLC_W) ? CNT_W : WLC_W;
  localparam int ACC_W    = FEAT_W + WGT_W + 1 + $clog2(NUM_FEAT);
  localparam int PRED_W   = ACC_W - 1;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NUM_EVT-1:0] evt = '0;
  logic is_l3 = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [WGT_W-1:0] data = '0;
  logic [PKT_W-1:0] pkt = '0;
  logic [RATE_W-1:0] rate = '0;
  logic [PRED_W-1:0] low = '0;
  logic [2:0] state;
  logic done;
  logic [PRED_W-1:0] pred;

  always #(CLK_PERIOD/2) clk = ~clk;

  inj_predict #(
    .NUM_FEAT(NUM_FEAT), .CNT_W(CNT_W), .WGT_W(WGT_W), .WIN_LEN(WIN_LEN),
    .WL_STEP(WL_STEP), .PKT_W(PKT_W), .RATE_W(RATE_W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .is_l3_i(is_l3),
    .wgt_we_i(we), .wgt_addr_i(addr), .wgt_data_i(data),
    .pkt_bits_i(pkt), .wl_rate_i(rate), .low_thr_i(low),
    .state_o(state), .done_o(done), .pred_o(pred)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;
  int wmod[NUM_FEAT];
  int cnt_m[NUM_EVT];
  int l3_m = 0;
  int exp_lvl = 4;
  longint pend_pred = 0;
  bit pend = 0;
  string pend_tag = "R4";

  function automatic longint wl_of(int l);
    return (l == 0) ? WL_STEP / 2 : WL_STEP * l;
  endfunction

  function automatic bit fits(longint p, longint pk, longint r, int l);
    return p * pk <= wl_of(l) * r;
  endfunction

  function automatic int exp_sel(longint p, longint lo, longint pk, longint r);
    if (p < lo) return 0;
    for (int k = 1; k <= 4; k++) if (fits(p, pk, r, k)) return k;
    return 4;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    end
  endtask

  // evm: 0 random, 1 none, 2 all; wm: 0 none, 1 random, 2 negative, 3 bogus addr; cm: config pattern
  task automatic run_window(int evm, int wm, int cm);
    int ndone = 0;
    longint p = pend_pred;
    longint pk, r, lo, sum;
    pk = 1; r = 1; lo = 0;
    case (cm)
      0: begin
        pk = $urandom_range(1, 255);
        r  = (p * pk) / (WL_STEP * $urandom_range(1, 5));
        lo = ($urandom_range(0, 3) == 0) ? p + 1 : 0;
      end
      1: begin pk = 16; r = p / 2; lo = 0; end
      2: begin pk = 1; r = 1000; lo = p + 1; end
      3: begin pk = 1; r = p; lo = p; end
      default: begin pk = 255; r = 1; lo = 0; end
    endcase
    if (r > 65535) r = 65535;
    pkt  = PKT_W'(pk);
    rate = RATE_W'(r);
    low  = PRED_W'(lo);
    l3_m = int'($urandom_range(0, 1));
    is_l3 = l3_m[0];
    for (int c = 1; c <= WIN_LEN; c++) begin
      int a = c - (NUM_FEAT + 3);
      logic [NUM_EVT-1:0] ev;
      for (int i = 0; i < NUM_EVT; i++)
        ev[i] = (evm == 2) ? 1'b1 : (evm == 1) ? 1'b0 : ($urandom_range(0, 3) == 0);
      evt = ev;
      we = 1'b0;
      if (wm != 0 && a >= 0 && a < NUM_FEAT) begin
        we = 1'b1;
        if (wm == 3) begin
          addr = AW'(NUM_FEAT + (c % 2));
          data = 16'h7fff;
        end else begin
          addr = AW'(a);
          if (wm == 1) data = WGT_W'($urandom_range(0, 2300) - 300);
          else         data = WGT_W'(-int'($urandom_range(1, 500)));
        end
      end
      @(posedge clk);
      for (int i = 0; i < NUM_EVT; i++)
        if (ev[i] && cnt_m[i] < CNT_MAX) cnt_m[i]++;
      if (we && int'(addr) < NUM_FEAT) wmod[addr] = int'($signed(data));
      @(negedge clk);
      we = 1'b0;
      if (done) ndone++;
      if (c == NUM_FEAT + 1 && pend) begin
        int es = exp_sel(p, lo, pk, r);
        string st;
        if (cm == 2 || cm == 3 || es == 0) st = "R6";
        else if (es == 4 && !fits(p, pk, r, 4)) st = "R8";
        else st = "R7";
        chk(done === 1'b1, "R5", "done at offset", longint'(done), 1);
        chk(longint'(pred) == p, pend_tag, "prediction", longint'(pred), p);
        chk(int'(state) == es, st, "state", longint'(state), es);
        exp_lvl = es;
      end
    end
    chk(ndone == (pend ? 1 : 0), "R5", "done pulses per window", ndone, pend ? 1 : 0);
    chk(int'(state) == exp_lvl, "R5", "state held", longint'(state), exp_lvl);
    sum = longint'(wmod[0]) * l3_m;
    for (int i = 0; i < NUM_EVT; i++) sum += longint'(wmod[i+1]) * cnt_m[i];
    sum += longint'(wmod[NUM_FEAT-1]) * wl_of(exp_lvl);
    pend_pred = (sum < 0) ? 0 : sum;
    pend = 1;
    pend_tag = (evm == 2) ? "R2" : (evm == 1) ? "R3" : (wm == 2) ? "R4" :
               (wm == 3 || wm == 1) ? "R9" : "R4";
    for (int i = 0; i < NUM_EVT; i++) cnt_m[i] = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NUM_FEAT; i++) wmod[i] = 0;
    for (int i = 0; i < NUM_EVT; i++) cnt_m[i] = 0;
    repeat (3) @(negedge clk);
    chk(state == 3'd4, "R1", "reset state", longint'(state), 4);
    chk(done == 1'b0, "R1", "reset done", longint'(done), 0);
    chk(pred == '0, "R1", "reset pred", longint'(pred), 0);
    rst_ni = 1'b1;
    for (int w = 0; w < 30; w++) begin
      int evm = (w == 6) ? 2 : (w == 9 || w == 10) ? 1 : 0;
      int wm  = (w == 0 || w == 15) ? 1 : (w == 12) ? 2 : (w == 20) ? 3 : 0;
      run_window(evm, wm, w % 5);
    end
    summary();
    $finish;
  end
endmodule